// File: doc/BRIEF.md
# Breathing LED Fader

This block makes one LED glow brighter and dimmer, over and over, with no outside help. A free-running 16-bit counter is its only state. The bottom seven bits of that counter form a fast sawtooth, and a seven-bit slice higher up sets the brightness. The LED is lit while the sawtooth is below the brightness, so the duty cycle follows the slice as it slowly climbs.

The counter's top bit flips that compare result on every other sweep of the brightness slice. As a result, the light ramps up and then ramps back down without an up/down counter. One complete fade, up and then down, takes 2^16 enabled clocks, and the counter simply wraps around.

An enable input freezes the fade: the counter and the LED both hold while it is low. The LED output is registered, so it never glitches. There is no data stream, so every pin is a plain control pin with no valid/ready handshake.

Top module: `breath_led`

## Requirements
- R1: While the synchronous active-high reset is asserted, the next clock clears the counter to 0 and drives the LED low, so the fade restarts dark.
- R2: On each clock edge with enable high and reset low, the counter (C) advances by exactly one.
- R3: The raw PWM bit is 1 when the ramp field C[6:0] is strictly below the level field C[14:8], and 0 otherwise. Bit C[7] takes no part in the compare, so each level lasts two PWM periods of 128 clocks.
- R4: The LED value is the raw PWM bit XOR C[15]. While C[15] is 1, the duty is inverted and the brightness falls.
- R5: The LED is registered. After an enabled edge, it shows the value computed from the counter as it stood just before that edge.
- R6: With enable low, the counter keeps its value and the LED keeps its level.
- R7: When C[15:8] is 0x00, the LED is fully off (level 0). When C[15:8] is 0x80, the LED is fully on.
- R8: After 0xFFFF, the counter wraps to 0x0000 with no special handling, and the fade pattern repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the fade |
| led | output | 1 | Registered LED drive, high = lit |

## Verification
Each result appears exactly one clock after the edge that produced it. The LED after an enabled edge reflects the pre-edge counter value, and a reset edge shows a dark LED on the next sample. The driver records the expected LED value for every edge as it applies that edge's inputs. The monitor samples one nanosecond after each rising edge, so every comparison meets the one-register latency. The same approach applies to held cycles, where the expected value is the previous one.

// File: rtl/breath_pkg.sv
package breath_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned RAMP_W  = 7;
  localparam int unsigned LVL_LSB = 8;
  localparam int unsigned LVL_W   = 7;
endpackage

// File: rtl/breath_counter.sv
module breath_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/breath_shade.sv
module breath_shade #(
  parameter int unsigned RW = 7,
  parameter int unsigned LW = 7
) (
  input  logic [RW-1:0] ramp,
  input  logic [LW-1:0] level,
  input  logic          flip,
  output logic          shade
);
  localparam int unsigned CW = (RW > LW) ? RW : LW;
  logic [CW-1:0] ramp_x, level_x;
  logic          below;

  always_comb begin
    ramp_x  = CW'(ramp);
    level_x = CW'(level);
    below   = ramp_x < level_x;
    shade   = below ^ flip;
  end
endmodule

// File: rtl/breath_outreg.sv
module breath_outreg (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/breath_led.sv
module breath_led
  import breath_pkg::*;
#(
  parameter int unsigned CW  = CNT_W,
  parameter int unsigned RW  = RAMP_W,
  parameter int unsigned LL  = LVL_LSB,
  parameter int unsigned LW  = LVL_W
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic led
);
  localparam int unsigned MSB = CW - 1;

  logic [CW-1:0] cnt_q;
  logic          shade_d;

  breath_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .cnt(cnt_q)
  );

  breath_shade #(.RW(RW), .LW(LW)) u_shade (
    .ramp (cnt_q[RW-1:0]),
    .level(cnt_q[LL +: LW]),
    .flip (cnt_q[MSB]),
    .shade(shade_d)
  );

  breath_outreg u_out (
    .clk(clk), .rst(rst), .en(en), .d(shade_d), .q(led)
  );
endmodule

// File: rtl/breath_led_chk.sv
module breath_led_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [CW-1:0] cnt,
  input logic          led
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !led));
  // R2
  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    en |=> cnt == $past(cnt) + 1'b1);
  // R6
  a_r6_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));
  a_r6_led_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(led));
  // R7
  a_r7_dark_floor: assert property (@(posedge clk) disable iff (rst)
    (en && cnt[CW-1:CW-8] == 8'h00) |=> !led);
  a_r7_bright_peak: assert property (@(posedge clk) disable iff (rst)
    (en && cnt[CW-1:CW-8] == 8'h80) |=> led);
  // R8
  a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == '1) |=> cnt == '0);
endmodule

bind breath_led breath_led_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .cnt(cnt_q), .led(led)
);

// File: tb/breath_led_tb.sv
module breath_led_tb;
  typedef struct {
    bit    val;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic led;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  exp_t q[$];
  logic [15:0] model = '0;
  bit last = 1'b0;

  always #2 clk = ~clk;

  breath_led u_dut (.clk(clk), .rst(rst), .en(en), .led(led));

  function automatic bit shade(input logic [15:0] c);
    return (c[6:0] < c[14:8]) ^ c[15];
  endfunction

  function automatic string tag(input logic [15:0] c);
    if (c[15:8] == 8'h00 || c[15:8] == 8'h80) return "R7";
    if (c == 16'hFFFF)                        return "R8";
    if (c[7:0] == 8'h00)                      return "R2";
    if (c[15])                                return "R4";
    return "R3";
  endfunction

  // driver: applies one edge's inputs and records what must follow it
  task automatic drive(input bit r, input bit e, input string force_tag = "");
    exp_t x;
    @(negedge clk);
    rst = r;
    en  = e;
    if (r) begin
      x.val = 1'b0; x.req = "R1";
      model = '0;
    end else if (e) begin
      x.val = shade(model);
      x.req = (force_tag != "") ? force_tag : tag(model);
      model = model + 16'd1;
    end else begin
      x.val = last; x.req = "R6";
    end
    last = x.val;
    q.push_back(x);
  endtask

  // monitor: one sample per edge, 1 ns after it
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if (led !== x.val) begin
        errors++;
        $display("FAIL %s: led=%b expected=%b", x.req, led, x.val);
      end
    end
  end

  initial begin
    repeat (3) drive(1, 0);                        // R1
    drive(0, 1, "R5");                             // R5 first enabled edge
    repeat (299) drive(0, 1);                      // R7 dark region, R3
    for (int i = 0; i < 40; i++) drive(0, (i % 3) == 0);  // R6
    while (model != 16'h0000) drive(0, 1);         // R3 R4 R7 R8 full fade
    repeat (300) drive(0, 1);                      // post-wrap repeat, R8
    drive(1, 1);                                   // R1 mid-run
    repeat (20) drive(0, 1);
    drive(0, 0);
    @(posedge clk); #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: led=%b expected=finished", led);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule